// File: doc/BRIEF.md
# Pulse-Width Infrared Frame Decoder

This block turns the demodulated output of an infrared receiver into code words. The receiver output rests high and signals with low-going pulses. The decoder passes that line through a synchroniser and then looks for a long low pulse that opens a frame. After the opening pulse, it sorts each later low pulse into a 0 or a 1 by its width. A frame closes when a high gap lasts longer than the bit threshold.

All thresholds are counted in clock ticks. `START_TICKS` is the shortest low pulse that is accepted as a frame opener, and the bit threshold is half of it. Frames carry any number of bits. The first bit received lands at bit 0 of the result. The word is right-justified by the number of bits actually received, and at most `CODE_W` bits are kept.

The result is presented as a plain strobe with no back-pressure. `frame_valid` is high for exactly one clock. `frame_code` and `frame_bits` take their new values in that same cycle and hold them until the next completed frame. A consumer that cannot take the result in the strobe cycle can still read it from the held outputs before the next frame completes.

Top module: `ir_pw_decoder`

## Requirements
- R1: After reset, `frame_valid` is 0 and `frame_code` and `frame_bits` are 0.
- R2: A low pulse of `START_TICKS` clocks or more, seen while hunting, opens a frame. A shorter low pulse is discarded, produces no strobe, and leaves the decoder hunting.
- R3: Inside a frame, a low pulse longer than `START_TICKS/2` clocks is a 1, and a low pulse of `START_TICKS/2` clocks or less is a 0.
- R4: A high gap of `START_TICKS/2` clocks or less keeps the frame open. A longer gap completes the frame, and the decoder returns to hunting.
- R5: The first data bit of a frame appears at `frame_code` bit 0 and later bits at rising positions. All positions at or above `frame_bits` read 0.
- R6: `frame_bits` equals the number of data bits received, saturating at `CODE_W`. Bits beyond `CODE_W` are dropped.
- R7: `frame_valid` lasts one clock per completed frame. `frame_code` and `frame_bits` change only in a strobe cycle and otherwise hold.
- R8: Accepting an opening pulse clears the collected code and count, so no bit of an earlier frame appears in a later one.
- R9: The width counters saturate. A low or high period far longer than the counter range is never measured as a short one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_rx_n | input | 1 | Demodulated receiver output, asynchronous; idles high, pulses are low |
| frame_valid | output | 1 | One-clock strobe when a frame completes |
| frame_code | output | CODE_W | Received code; first bit at bit 0, right-justified |
| frame_bits | output | $clog2(CODE_W+1) | Number of bits in `frame_code` |

## Verification
The assertions assume that `ir_rx_n` holds each level for at least one full clock and rests high through reset. A low that is already present when reset is released would not register as a falling edge. The bench changes the input only on falling clock edges, holds every level for a whole number of clocks, and keeps the line high during reset. The bench sets `START_TICKS` to 20, which puts the bit threshold at 10. Pulse and gap widths are chosen on both sides of each threshold, and some run well past the counter range.

// File: rtl/ir_pw_pkg.sv
package ir_pw_pkg;

  // Decoder phases: hunting for an opener, timing a high gap, timing a data low.
  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_GAP  = 2'd1,
    PH_LOW  = 2'd2
  } dec_phase_e;

  // Width of a counter that can hold values up to and including max_val.
  function automatic int unsigned cnt_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ir_pw_sync.sv
// Synchroniser chain plus edge detection on the settled level.
module ir_pw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fell,
  output logic rose
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b1;
    else        last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fell  = last & ~level;
  assign rose  = ~last & level;

endmodule

// File: rtl/ir_pw_timer.sv
// Saturating period counter. Reads 1 in the first cycle after a restart.
module ir_pw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] ticks
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ticks <= '0;
    else if (restart)       ticks <= CNT_W'(1);
    else if (ticks != TOP)  ticks <= ticks + CNT_W'(1);
  end

endmodule

// File: rtl/ir_pw_collect.sv
// Bit collector: new bits enter at the top, and the result is shifted down by
// the number of unused positions, so the first bit lands at bit 0.
module ir_pw_collect #(
  parameter int CODE_W = 32,
  parameter int NB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              bit_in,
  output logic [CODE_W-1:0] code,
  output logic [NB_W-1:0]   count
);

  localparam logic [NB_W-1:0] FULL = NB_W'(CODE_W);

  logic [CODE_W-1:0] shreg;
  logic [NB_W-1:0]   unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      count <= '0;
    end else if (clear) begin
      shreg <= '0;
      count <= '0;
    end else if (push && (count != FULL)) begin
      shreg <= {bit_in, shreg[CODE_W-1:1]};
      count <= count + NB_W'(1);
    end
  end

  always_comb begin
    unused = FULL - count;
    code   = shreg >> unused;
  end

endmodule

// File: rtl/ir_pw_decoder.sv
module ir_pw_decoder #(
  parameter int START_TICKS = 270000,
  parameter int CODE_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ir_rx_n,
  output logic                                   frame_valid,
  output logic [CODE_W-1:0]                      frame_code,
  output logic [ir_pw_pkg::cnt_bits(CODE_W)-1:0] frame_bits
);
  import ir_pw_pkg::*;

  localparam int BIT_TICKS = START_TICKS / 2;
  localparam int CNT_W     = cnt_bits(START_TICKS) + 1;
  localparam int NB_W      = cnt_bits(CODE_W);
  localparam logic [CNT_W-1:0] START_LIM = CNT_W'(START_TICKS);
  localparam logic [CNT_W-1:0] BIT_LIM   = CNT_W'(BIT_TICKS);

  logic             lvl, fell, rose;
  logic [CNT_W-1:0] ticks;
  logic             tmr_restart;
  dec_phase_e       phase, phase_nx;
  logic             open_frame, take_bit, bit_val, close_frame;
  logic [CODE_W-1:0] col_code;
  logic [NB_W-1:0]   col_count;

  ir_pw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ir_rx_n),
    .level(lvl), .fell(fell), .rose(rose)
  );

  assign tmr_restart = fell | rose;

  ir_pw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .ticks(ticks)
  );

  // On a rise, ticks equals the length of the low that just ended.
  // While in PH_GAP, ticks equals the high time so far.
  always_comb begin
    phase_nx    = phase;
    open_frame  = 1'b0;
    take_bit    = 1'b0;
    close_frame = 1'b0;
    bit_val     = (ticks > BIT_LIM);
    unique case (phase)
      PH_HUNT: begin
        if (rose && (ticks >= START_LIM)) begin
          open_frame = 1'b1;
          phase_nx   = PH_GAP;
        end
      end
      PH_GAP: begin
        if (ticks > BIT_LIM) begin
          close_frame = 1'b1;
          phase_nx    = PH_HUNT;
        end else if (fell) begin
          phase_nx = PH_LOW;
        end
      end
      PH_LOW: begin
        if (rose) begin
          take_bit = 1'b1;
          phase_nx = PH_GAP;
        end
      end
      default: phase_nx = PH_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_HUNT;
    else        phase <= phase_nx;
  end

  ir_pw_collect #(.CODE_W(CODE_W), .NB_W(NB_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .clear(open_frame), .push(take_bit),
    .bit_in(bit_val), .code(col_code), .count(col_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid <= 1'b0;
      frame_code  <= '0;
      frame_bits  <= '0;
    end else begin
      frame_valid <= close_frame;
      if (close_frame) begin
        frame_code <= col_code;
        frame_bits <= col_count;
      end
    end
  end

  logic unused_lvl;
  assign unused_lvl = lvl;

endmodule

// File: rtl/ir_pw_decoder_chk.sv
module ir_pw_decoder_chk #(
  parameter int CODE_W = 32,
  parameter int NB_W   = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_valid,
  input logic [CODE_W-1:0] frame_code,
  input logic [NB_W-1:0]   frame_bits,
  input logic              tmr_restart,
  input logic [CNT_W-1:0]  ticks
);

  localparam logic [CNT_W-1:0] TOP = '1;

  // R7: strobe lasts a single clock
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R7: results hold outside strobe cycles
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(frame_code) && $stable(frame_bits)));

  // R5: nothing set at or above the bit count
  p_code_justified_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ((frame_code >> frame_bits) == '0));

  // R6: count never exceeds the code width
  p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bits <= NB_W'(CODE_W));

  // R9: a saturated counter stays saturated until restarted
  p_timer_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ticks == TOP && !tmr_restart) |=> (ticks == TOP));

  // R9: an edge restarts the period count
  p_timer_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_restart |=> (ticks == CNT_W'(1)));

endmodule

bind ir_pw_decoder ir_pw_decoder_chk #(
  .CODE_W(CODE_W), .NB_W(NB_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
  .frame_code(frame_code), .frame_bits(frame_bits),
  .tmr_restart(tmr_restart), .ticks(ticks)
);

// File: tb/sim_ir_pw_decoder.sv
`timescale 1ns/1ps
module sim_ir_pw_decoder;
  localparam int START = 20;
  localparam int BITT  = START / 2;
  localparam int CW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir = 1'b1;
  logic fv;
  logic [CW-1:0] fc;
  logic [5:0] fb;

  int checks = 0;
  int errors = 0;
  int frames = 0;
  int double_strobe = 0;
  logic prev_fv = 1'b0;
  logic [CW-1:0] exp_code;
  int exp_n;

  always #4 clk = ~clk;

  ir_pw_decoder #(.START_TICKS(START), .CODE_W(CW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_rx_n(ir),
    .frame_valid(fv), .frame_code(fc), .frame_bits(fb)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (fv) frames++;
      if (fv && prev_fv) double_strobe++;
      prev_fv <= fv;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic lo(input int w);
    ir = 1'b0;
    repeat (w) @(negedge clk);
    ir = 1'b1;
  endtask

  task automatic hi(input int w);
    ir = 1'b1;
    repeat (w) @(negedge clk);
  endtask

  task automatic expect_bit(input bit b);
    if (exp_n < CW) begin
      exp_code[exp_n] = b;
      exp_n++;
    end
  endtask

  task automatic check_frame(input int f0, input string req);
    chk(frames == f0 + 1, req, frames - f0, 1);
    chk(fc == exp_code, req, fc, exp_code);
    chk(fb == 6'(exp_n), req, fb, exp_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int f0;
    logic [CW-1:0] keep;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(fv == 1'b0 && fc == '0 && fb == '0, "R1", {fv, fc, fb}, 0);
    rst_n = 1'b1;
    hi(10);

    // R2: opener one tick short is discarded
    f0 = frames;
    lo(START - 1); hi(4); lo(13); hi(40);
    chk(frames == f0, "R2 short opener", frames - f0, 0);
    // R2: exact opener accepted; R3 boundaries 10 -> 0, 11 -> 1
    f0 = frames; exp_code = '0; exp_n = 0;
    lo(START);
    hi(3); lo(BITT);     expect_bit(1'b0);
    hi(3); lo(BITT + 1); expect_bit(1'b1);
    hi(3); lo(BITT);     expect_bit(1'b0);
    hi(3); lo(BITT + 1); expect_bit(1'b1);
    hi(40);
    check_frame(f0, "R2 R3 thresholds");
    chk(fc == 32'hA, "R5 lsb first", fc, 32'hA);

    // R4: gaps of exactly BITT keep the frame open
    f0 = frames; exp_code = '0; exp_n = 0;
    lo(START);
    for (int i = 0; i < 5; i++) begin
      hi(BITT); lo((i % 2) ? 14 : 4); expect_bit(i % 2 == 1);
    end
    hi(40);
    check_frame(f0, "R4 gap at limit");

    // R4: gap one over the limit ends the frame; the tail is ignored
    f0 = frames; exp_code = '0; exp_n = 0;
    lo(START);
    hi(3); lo(14); expect_bit(1'b1);
    hi(BITT + 1); lo(14); hi(3); lo(4); hi(40);
    check_frame(f0, "R4 gap over limit");

    // R7: a rejected opener leaves the held result untouched
    keep = fc; f0 = frames;
    lo(5); hi(30);
    chk(frames == f0 && fc == keep && fb == 6'd1, "R7 hold", fc, keep);

    // R9: very long low still counts as an opener, long data low is a 1
    f0 = frames; exp_code = '0; exp_n = 0;
    lo(200);
    hi(2); lo(200); expect_bit(1'b1);
    hi(2); lo(3);   expect_bit(1'b0);
    hi(300);
    check_frame(f0, "R9 saturation");

    // R5 R6 R8: sweep of bit counts 0..35 with varied widths and gaps
    for (int n = 0; n <= 35; n++) begin
      logic [CW-1:0] pat;
      int gap;
      pat = 32'hA5C3_0F69 ^ (32'(n) * 32'h9E37_79B9);
      gap = 2 + (n % 9);
      f0 = frames; exp_code = '0; exp_n = 0;
      lo(START + (n % 3));
      for (int i = 0; i < n; i++) begin
        bit b;
        b = pat[i % 32] ^ (i >= 32);
        hi(gap);
        lo(b ? (BITT + 1 + (i % 4)) : (2 + (i % 9)));
        expect_bit(b);
      end
      hi(40);
      check_frame(f0, "R6 R8 sweep");
      chk((fc >> fb) == '0, "R5 justified", fc >> fb, 0);
    end

    chk(double_strobe == 0, "R7 single strobe", double_strobe, 0);
    finish_run();
  end
endmodule